// File: doc/BRIEF.md
# Staggered Row Launch Scheduler

This controller sequences one frame of work across a column of FFT row engines that share a single, narrower phase-compensation row. When a frame is requested it starts the FFT rows one at a time, in ascending row index. Consecutive starts are spaced by the number of cycles the phase-compensation row needs to process one row of data. The point count comes from a configured power-of-two size and is divided by the lane width of the phase-compensation row. Because of this spacing, the FFT rows tend to finish one after another, and each finished row gets a full compensation window of the same length.

Each FFT row reports its completion with a one-cycle pulse. The scheduler gives the compensation row to each finished row strictly in row order, one window at a time. When the next row has already finished, its window follows the previous one without a gap. The frame ends when the last row's window closes: the busy flag drops and a one-cycle end pulse is produced.

A frame request that arrives while a frame is in progress is remembered and launched as soon as the current frame ends. Two image blocks processed in parallel use one instance of this block each.

Top module: `stagger_sched`

## Requirements
- R1: After reset, `row_start`, `busy`, `pc_active`, `frame_done` and `pc_row` are all zero.
- R2: A `frame_req` sampled high while `busy` is low launches a frame. `row_start[0]` pulses in the next cycle and `busy` is high from that cycle. `row_start` never has more than one bit set, and bit k means row k.
- R3: The spacing S, in cycles, between consecutive row starts is 2^(cfg_log2_pts − 4), giving 16 points per compensation cycle. Rows start in ascending index with exactly S cycles between neighbours, so row k starts S·k cycles after row 0.
- R4: A `cfg_log2_pts` below 4 is treated as 4 (S = 1). A value above 12 is treated as 12 (S = 256).
- R5: The size is captured in the launch cycle. Any change of `cfg_log2_pts` during a frame has no effect on that frame's spacing or window lengths.
- R6: If `row_done[k]` is high in cycle c while busy, the compensation window for row k opens no earlier than cycle c+2. Windows are served in ascending row order and each lasts S cycles, with `pc_active` high and `pc_row` equal to k. A window opens at the later of c+2 and the cycle after the previous window ends.
- R7: In the cycle after the last cycle of row 15's window, `busy` is low and `frame_done` is high for exactly one cycle.
- R8: A `frame_req` that arrives while busy is held. The held request launches in the first cycle `busy` is low, so `row_start[0]` pulses in the cycle after that. A held request launches exactly one frame.
- R9: `row_done` pulses while no frame is in progress are ignored, and do not open a window in a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_req | input | 1 | Frame start request |
| cfg_log2_pts | input | 4 | Log2 of the points per row |
| row_done | input | 16 | Per-row FFT completion pulses |
| row_start | output | 16 | Per-row FFT start pulses |
| busy | output | 1 | Frame in progress |
| pc_active | output | 1 | Compensation window open |
| pc_row | output | 4 | Row currently being compensated |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The in-module properties check the following on every cycle:
- At most one start pulse is active at a time.
- No start or compensation activity happens outside a frame.
- Every row start after row 0 comes exactly the latched spacing after the previous start.
- The end pulse only follows the final cycle of row 15's window.

The directed scenarios cover what depends on the bench's completion timing:
- The exact cycle each window opens when rows finish out of order.
- The total compensation time.
- Clamping of out-of-range sizes.
- Relaunch of a held request.
- Completions seen while idle being ignored.

// File: rtl/stagger_sched.sv
module stagger_sched #(
  parameter int ROWS     = 16,
  parameter int LANES    = 16,
  parameter int MAX_LOG2 = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_req,
  input  logic [$clog2(MAX_LOG2+1)-1:0] cfg_log2_pts,
  input  logic [ROWS-1:0]               row_done,
  output logic [ROWS-1:0]               row_start,
  output logic                          busy,
  output logic                          pc_active,
  output logic [$clog2(ROWS)-1:0]       pc_row,
  output logic                          frame_done
);
  localparam int LANE_LOG2 = $clog2(LANES);
  localparam int LW        = $clog2(MAX_LOG2+1);
  localparam int RW        = $clog2(ROWS);
  localparam int SW        = MAX_LOG2 - LANE_LOG2 + 1;
  localparam logic [LW-1:0] CMAX  = LW'(MAX_LOG2);
  localparam logic [LW-1:0] CMIN  = LW'(LANE_LOG2);
  localparam logic [RW:0]   NROWS = (RW+1)'(ROWS);
  localparam logic [RW-1:0] LAST  = RW'(ROWS-1);

  logic [LW-1:0] cfg_c;
  logic [SW-1:0] stg_nx, stg_q, tmr, pc_cnt;
  logic [RW:0]   nxt_row;
  logic [RW-1:0] nrow;
  logic [ROWS-1:0] pend;
  logic req_hold, launch, last_cyc, fin;

  assign cfg_c    = (cfg_log2_pts > CMAX) ? CMAX : ((cfg_log2_pts < CMIN) ? CMIN : cfg_log2_pts);
  assign stg_nx   = {{(SW-1){1'b0}}, 1'b1} << (cfg_c - CMIN);
  assign launch   = !busy && (frame_req || req_hold);
  assign nrow     = pc_row + 1'b1;
  assign last_cyc = pc_active && (pc_cnt == stg_q - 1'b1);
  assign fin      = last_cyc && (pc_row == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_hold <= 1'b0;
      busy     <= 1'b0;
      frame_done <= 1'b0;
      stg_q    <= '0;
    end else begin
      if (launch) req_hold <= 1'b0;
      else if (frame_req) req_hold <= 1'b1;
      if (launch) begin
        busy  <= 1'b1;
        stg_q <= stg_nx;
      end else if (fin) begin
        busy <= 1'b0;
      end
      frame_done <= fin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_start <= '0;
      tmr       <= '0;
      nxt_row   <= '0;
    end else if (launch) begin
      row_start <= ROWS'(1);
      tmr       <= '0;
      nxt_row   <= (RW+1)'(1);
    end else if (busy && nxt_row != NROWS) begin
      if (tmr == stg_q - 1'b1) begin
        row_start <= ROWS'(1) << nxt_row;
        nxt_row   <= nxt_row + 1'b1;
        tmr       <= '0;
      end else begin
        row_start <= '0;
        tmr       <= tmr + 1'b1;
      end
    end else begin
      row_start <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || launch || !busy) pend <= '0;
    else                           pend <= pend | row_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      pc_active <= 1'b0;
      pc_row    <= '0;
      pc_cnt    <= '0;
    end else if (busy) begin
      if (!pc_active) begin
        if (pend[pc_row]) begin
          pc_active <= 1'b1;
          pc_cnt    <= '0;
        end
      end else if (last_cyc) begin
        pc_cnt <= '0;
        if (fin) begin
          pc_active <= 1'b0;
        end else begin
          pc_row    <= nrow;
          pc_active <= pend[nrow];
        end
      end else begin
        pc_cnt <= pc_cnt + 1'b1;
      end
    end
  end

  logic [SW:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n) gap_q <= '0;
    else if (row_start != '0) gap_q <= (SW+1)'(1);
    else if (gap_q != {(SW+1){1'b1}}) gap_q <= gap_q + 1'b1;
  end

  p_onehot_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_start));
  p_start_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_start != '0) |-> busy);
  p_row_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_start != '0) && !row_start[0]) |-> (gap_q == {1'b0, stg_q}));
  p_window_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_active |-> busy);
  p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && $past(pc_active) && ($past(pc_row) == LAST)));
endmodule

// File: tb/test_stagger_sched.sv
module test_stagger_sched;
  localparam int ROWS = 16;
  logic clk = 1'b0, rst_n = 1'b0, frame_req = 1'b0;
  logic [3:0] cfg_log2_pts = 4'd10;
  logic [ROWS-1:0] row_done, man_done = '0, auto_done;
  logic [ROWS-1:0] row_start;
  logic busy, pc_active, frame_done;
  logic [3:0] pc_row;

  int checks = 0, errors = 0, cyc = 0;
  int start_t[ROWS], lat[ROWS], win_t[ROWS], win_row[ROWS];
  int nwin, nstarts, pc_cycles, fall_t, fd_t, fd_cnt, multi;
  logic prev_busy = 1'b0, prev_pc = 1'b0;
  logic [3:0] prev_row = '0;

  always #4 clk = ~clk;
  assign row_done = auto_done | man_done;

  stagger_sched i_stagger_sched (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .cfg_log2_pts(cfg_log2_pts),
    .row_done(row_done), .row_start(row_start), .busy(busy), .pc_active(pc_active),
    .pc_row(pc_row), .frame_done(frame_done));

  always @(negedge clk) begin
    cyc = cyc + 1;
    if ($countones(row_start) > 1) multi = multi + 1;
    for (int k = 0; k < ROWS; k++)
      if (row_start[k]) begin start_t[k] = cyc; nstarts = nstarts + 1; end
    if (pc_active && (!prev_pc || pc_row != prev_row)) begin
      if (nwin < ROWS) begin win_t[nwin] = cyc; win_row[nwin] = int'(pc_row); end
      nwin = nwin + 1;
    end
    if (pc_active) pc_cycles = pc_cycles + 1;
    if (prev_busy && !busy) fall_t = cyc;
    if (frame_done) begin fd_t = cyc; fd_cnt = fd_cnt + 1; end
    prev_busy = busy; prev_pc = pc_active; prev_row = pc_row;
    for (int k = 0; k < ROWS; k++) auto_done[k] = (cyc == start_t[k] + lat[k]);
    if (cyc > 150000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic clear_logs();
    nwin = 0; nstarts = 0; pc_cycles = 0; fd_cnt = 0; multi = 0; fall_t = -1; fd_t = -2;
    for (int k = 0; k < ROWS; k++) start_t[k] = -100000;
  endtask

  task automatic wait_done(input int n);
    int lim = 0;
    while (fd_cnt < n && lim < 20000) begin @(negedge clk); lim++; end
  endtask

  task automatic test_reset();
    @(negedge clk); #1;
    chk(row_start == '0 && busy == 0, "R1 start/busy after reset", int'(row_start), 0);
    chk(pc_active == 0 && frame_done == 0 && pc_row == 0, "R1 window outputs after reset",
        int'({pc_active, frame_done, pc_row}), 0);
  endtask

  task automatic run_frame(input int cfg, input int s, input int l0, input int lr, input string tag);
    int r, bad, wbad, w[ROWS];
    clear_logs();
    for (int k = 0; k < ROWS; k++) lat[k] = (k == 0) ? l0 : lr;
    @(negedge clk); #1; r = cyc; cfg_log2_pts = 4'(cfg); frame_req = 1'b1;
    @(negedge clk); #1; frame_req = 1'b0; cfg_log2_pts = 4'd0;  // R5: change ignored
    wait_done(1);
    @(negedge clk); #1;
    chk(start_t[0] == r + 1, {tag, " R2 row 0 start cycle"}, start_t[0], r + 1);
    chk(multi == 0 && nstarts == ROWS, {tag, " R2 one start per row"}, nstarts, ROWS);
    bad = 0;
    for (int k = 1; k < ROWS; k++) if (start_t[k] - start_t[k-1] != s) bad++;
    chk(bad == 0, {tag, " R3 R4 R5 start spacing mismatches"}, bad, 0);
    for (int k = 0; k < ROWS; k++) begin
      w[k] = start_t[k] + lat[k] + 2;
      if (k > 0 && w[k-1] + s > w[k]) w[k] = w[k-1] + s;
    end
    wbad = 0;
    for (int k = 0; k < ROWS; k++) if (win_t[k] != w[k] || win_row[k] != k) wbad++;
    chk(nwin == ROWS && wbad == 0, {tag, " R6 window order/timing mismatches"}, wbad + nwin - ROWS, 0);
    chk(pc_cycles == ROWS * s, {tag, " R6 compensation cycles"}, pc_cycles, ROWS * s);
    chk(fall_t == w[ROWS-1] + s, {tag, " R7 busy fall cycle"}, fall_t, w[ROWS-1] + s);
    chk(fd_t == fall_t && fd_cnt == 1, {tag, " R7 single end pulse"}, fd_t, fall_t);
  endtask

  task automatic test_held();
    int f1;
    clear_logs();
    for (int k = 0; k < ROWS; k++) lat[k] = 3;
    @(negedge clk); #1; cfg_log2_pts = 4'd6; frame_req = 1'b1;
    @(negedge clk); #1; frame_req = 1'b0;
    repeat (10) @(negedge clk);
    #1; frame_req = 1'b1;
    @(negedge clk); #1; frame_req = 1'b0;
    wait_done(1);
    f1 = fall_t;
    @(negedge clk); #1;
    chk(start_t[0] == f1 + 1, "R8 held request relaunch cycle", start_t[0], f1 + 1);
    chk(busy == 1, "R8 busy in relaunched frame", int'(busy), 1);
    wait_done(2);
    repeat (6) @(negedge clk);
    #1;
    chk(busy == 0 && fd_cnt == 2, "R8 held request launches one frame", fd_cnt, 2);
  endtask

  task automatic test_idle_done();
    @(negedge clk); #1; man_done = '1;
    @(negedge clk); #1; man_done = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && pc_active == 0, "R9 idle completion no activity", int'({busy, pc_active}), 0);
    run_frame(8, 16, 48, 5, "R9 stale completion");
  endtask

  initial begin
    for (int k = 0; k < ROWS; k++) lat[k] = 1000000;
    clear_logs();
    repeat (3) @(negedge clk);
    #1; rst_n = 1'b1;
    test_reset();
    run_frame(10, 64, 5, 5, "1024pt");
    run_frame(6, 4, 2, 2, "64pt");
    run_frame(12, 256, 10, 10, "4096pt");
    run_frame(2, 1, 1, 1, "clamp low R4");
    run_frame(15, 256, 3, 7, "clamp high R4");
    run_frame(8, 16, 70, 20, "out of order R6");
    test_held();
    test_idle_done();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule